// File: doc/BRIEF.md
# Seven-to-One Four-Lane Serial Transmitter

This block takes a 28-bit parallel word once per pixel period and sends it out as four serial data lanes plus a fifth lane carrying a fixed framing pattern. Each lane carries seven bits per pixel period, so the block runs on a bit clock at seven times the pixel rate. A pixel rate of 85 MHz gives a 595 MHz bit clock. A strobe input, high for one bit-clock cycle per pixel period and phase-aligned with the pixel clock, marks where each word enters. The outputs are single-ended logic stand-ins for the differential pairs. No error detection or retransmission is applied to the data.

The input is a valid/ready stream, and ready simply follows the strobe. The block never holds off the source for any other reason. A source that wants its word sent must hold it, with valid high, until a strobe cycle accepts it. A strobe cycle with valid low is not an error: that slot goes out as zeros on every data lane, while the framing lane keeps its pattern. Each accepted word is captured into a holding register, and one cycle later it is copied into per-lane shift registers. Because of this, input activity between strobes cannot tear a word that is already on the wire.

Top module: `ser7_lane_tx`

## Requirements
- R1: After reset, and until the first slot boundary, every data lane and the framing lane output 0.
- R2: A word accepted at the rising edge where `pclk_strobe` is high shows its first serial bit after the second rising edge from then. Its bits then appear on seven consecutive cycles. Lane k carries word bits 7k+6 down to 7k, most-significant bit first.
- R3: During each seven-bit slot, the framing lane outputs 1,1,0,0,0,1,1 in that order, with the first bit aligned to the first bit of the slot's data.
- R4: `in_ready` is high exactly in cycles where `pclk_strobe` is high. A word is transferred only on a cycle where both `in_valid` and `in_ready` are high.
- R5: If `in_valid` is low at a strobe, the resulting slot carries 0 on all four data lanes, and the framing lane still shows its pattern.
- R6: Changes to `in_word` or `in_valid` on cycles without a strobe have no effect on any slot.
- R7: When strobes are spaced seven cycles apart, successive slots follow with no gap. When strobes stop, all lanes, including the framing lane, fall to 0 once the last slot has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_strobe | input | 1 | One-cycle pixel-phase marker, every seventh cycle |
| in_valid | input | 1 | Source holds a word to send |
| in_word | input | 28 | Parallel word, bits 7k..7k+6 belong to lane k |
| in_ready | output | 1 | Word is taken this cycle (equals strobe) |
| lane_out | output | 4 | Serial data lanes, bit k is lane k |
| clk_lane | output | 1 | Framing lane carrying the fixed seven-bit pattern |

## Verification
A corrupted holding register or shift register shows up on a data lane within two to eight bit cycles of the strobe that loaded it. The error appears as a wrong bit at a fixed offset inside one slot. A misplaced slot-boundary pulse shifts the framing pattern, so the framing lane diverges from 1100011 on the first slot after the fault. Every data-lane bit in that same slot is then offset too. A slot that leaks data after the strobes stop shows a non-zero bit immediately after the seventh bit of the final slot.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_RATIO = 7;
  // Framing pattern, MSB transmitted first in each slot.
  localparam logic [6:0] DEF_FRAME_PAT = 7'b1100011;
endpackage

// File: rtl/ser7_word_hold.sv
module ser7_word_hold #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              keep,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] hold,
  output logic              slot_load
);
  // First stage of the double buffer: captured at the strobe, copied to the
  // shifters one cycle later, so later input activity cannot tear it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      slot_load <= 1'b0;
    end else begin
      slot_load <= take;
      if (take) hold <= keep ? din : '0;
    end
  end
endmodule

// File: rtl/ser7_lane_shift.sv
module ser7_lane_shift #(
  parameter int unsigned RATIO = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RATIO-1:0] par,
  output logic             ser
);
  logic [RATIO-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)    sr <= '0;
    else if (load) sr <= par;
    else           sr <= {sr[RATIO-2:0], 1'b0};
  end

  assign ser = sr[RATIO-1];
endmodule

// File: rtl/ser7_lane_tx.sv
module ser7_lane_tx
  import ser7_pkg::*;
#(
  parameter int unsigned      LANES       = DEF_LANES,
  parameter int unsigned      RATIO       = DEF_RATIO,
  parameter logic [RATIO-1:0] CLK_PATTERN = DEF_FRAME_PAT,
  localparam int unsigned     WORD_W      = LANES * RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_strobe,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic [LANES-1:0]  lane_out,
  output logic              clk_lane
);
  logic [WORD_W-1:0] hold;
  logic              slot_load;

  assign in_ready = pclk_strobe;

  ser7_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (pclk_strobe),
    .keep      (in_valid),
    .din       (in_word),
    .hold      (hold),
    .slot_load (slot_load)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser7_lane_shift #(.RATIO(RATIO)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (slot_load),
      .par   (hold[g*RATIO +: RATIO]),
      .ser   (lane_out[g])
    );
  end

  ser7_lane_shift #(.RATIO(RATIO)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (slot_load),
    .par   (CLK_PATTERN),
    .ser   (clk_lane)
  );
endmodule

// File: rtl/ser7_lane_tx_chk.sv
module ser7_lane_tx_chk #(
  parameter int unsigned      LANES       = 4,
  parameter int unsigned      RATIO       = 7,
  parameter logic [RATIO-1:0] CLK_PATTERN = 7'b1100011,
  localparam int unsigned     WORD_W      = LANES * RATIO,
  localparam int unsigned     POS_W       = $clog2(RATIO + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pclk_strobe,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic [LANES-1:0]  lane_out,
  input logic              clk_lane
);
  logic             load_c;
  logic             started;
  logic [POS_W-1:0] pos;
  logic             exp_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_c  <= 1'b0;
      started <= 1'b0;
      pos     <= POS_W'(RATIO);
    end else begin
      load_c <= pclk_strobe;
      if (load_c) begin
        started <= 1'b1;
        pos     <= '0;
      end else if (pos < POS_W'(RATIO)) begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    exp_clk = 1'b0;
    for (int i = 0; i < RATIO; i++)
      if (pos == POS_W'(i)) exp_clk = CLK_PATTERN[RATIO-1-i];
  end

  p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (lane_out == '0 && !clk_lane));

  p_frame_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && pos < POS_W'(RATIO)) |-> (clk_lane == exp_clk));

  p_idle_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_strobe && !in_valid) |=> ##1 (lane_out == '0));

  p_drain_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && pos == POS_W'(RATIO)) |-> (lane_out == '0 && !clk_lane));

  for (genvar k = 0; k < LANES; k++) begin : g_first
    p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pclk_strobe && in_valid) |=> ##1
        (lane_out[k] == $past(in_word[k*RATIO + RATIO - 1], 2)));
  end
endmodule

bind ser7_lane_tx ser7_lane_tx_chk #(
  .LANES(LANES), .RATIO(RATIO), .CLK_PATTERN(CLK_PATTERN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pclk_strobe(pclk_strobe), .in_valid(in_valid),
  .in_word(in_word), .lane_out(lane_out), .clk_lane(clk_lane)
);

// File: tb/sim_ser7_lane_tx.sv
module sim_ser7_lane_tx;
  localparam int LANES = 4;
  localparam int RATIO = 7;
  localparam int W     = LANES * RATIO;
  localparam logic [RATIO-1:0] PAT = 7'b1100011;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pclk_strobe;
  logic             in_valid;
  logic [W-1:0]     in_word;
  logic             in_ready;
  logic [LANES-1:0] lane_out;
  logic             clk_lane;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model state, from the requirements.
  logic [W-1:0] pend, cur;
  string        pend_tag, cur_tag;
  bit           load_flag, started;
  int           bitpos;

  always #5 clk = ~clk;

  ser7_lane_tx u0 (
    .clk(clk), .rst_n(rst_n), .pclk_strobe(pclk_strobe), .in_valid(in_valid),
    .in_word(in_word), .in_ready(in_ready), .lane_out(lane_out), .clk_lane(clk_lane)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] exp_lanes(input logic [W-1:0] w, input int p);
    logic [LANES-1:0] v = '0;
    if (p < RATIO)
      for (int k = 0; k < LANES; k++) v[k] = w[k*RATIO + RATIO - 1 - p];
    return v;
  endfunction

  function automatic logic exp_frame(input int p);
    return (p < RATIO) ? PAT[RATIO-1-p] : 1'b0;
  endfunction

  task automatic model_reset();
    pend = '0; cur = '0; load_flag = 0; started = 0; bitpos = RATIO;
    pend_tag = "R2"; cur_tag = "R2";
  endtask

  // One bit cycle: drive at negedge, follow the edge, sample at next negedge.
  task automatic step(input bit strb, input bit vld, input logic [W-1:0] wd, input string tag);
    pclk_strobe = strb; in_valid = vld; in_word = wd;
    #1;
    chk(in_ready == strb, "R4 ready", 32'(in_ready), 32'(strb));
    @(posedge clk);
    if (load_flag) begin cur = pend; cur_tag = pend_tag; bitpos = 0; started = 1; end
    else if (bitpos < RATIO) bitpos++;
    load_flag = strb;
    if (strb) begin pend = vld ? wd : '0; pend_tag = tag; end
    @(negedge clk);
    if (!started) begin
      chk(lane_out == '0 && !clk_lane, "R1 quiet", 32'({clk_lane, lane_out}), 32'h0);
    end else if (bitpos >= RATIO) begin
      chk(lane_out == '0 && !clk_lane, "R7 drain", 32'({clk_lane, lane_out}), 32'h0);
    end else begin
      chk(lane_out == exp_lanes(cur, bitpos), cur_tag, 32'(lane_out), 32'(exp_lanes(cur, bitpos)));
      chk(clk_lane == exp_frame(bitpos), "R3 frame", 32'(clk_lane), 32'(exp_frame(bitpos)));
    end
  endtask

  // One slot: strobe cycle, then six cycles with optional input noise (R6).
  task automatic slot(input bit vld, input logic [W-1:0] wd, input bit noise, input string tag);
    step(1'b1, vld, wd, tag);
    for (int i = 1; i < RATIO; i++)
      if (noise) step(1'b0, 1'($urandom()), W'($urandom()), tag);
      else       step(1'b0, vld, wd, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20517);
    model_reset();
    rst_n = 1'b0; pclk_strobe = 1'b0; in_valid = 1'b0; in_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lane_out == '0 && !clk_lane, "R1 reset", 32'({clk_lane, lane_out}), 32'h0);
    rst_n = 1'b1;

    // R1: quiet until the first slot boundary, even with input activity.
    step(1'b0, 1'b1, 28'hFFFFFFF, "R1");
    step(1'b0, 1'b1, 28'h1234567, "R1");
    step(1'b0, 1'b0, 28'h0, "R1");

    // R2 directed corner words, back to back (R7 contiguity).
    slot(1'b1, 28'hFFFFFFF, 1'b0, "R2 ones");
    slot(1'b1, 28'h5555555, 1'b0, "R2 alt");
    slot(1'b1, 28'h0000001, 1'b0, "R2 lsb");
    slot(1'b1, 28'h8000000, 1'b0, "R2 msb");
    slot(1'b1, 28'h0204081, 1'b0, "R2 lane-lsbs");
    slot(1'b1, 28'h8102040, 1'b0, "R2 lane-msbs");
    // R5: idle slot with a non-zero word on the bus.
    slot(1'b0, 28'hFFFFFFF, 1'b0, "R5 idle");
    slot(1'b1, 28'hA5C3F0E, 1'b0, "R2 after-idle");

    // R6: random words with input noise between strobes, some idle slots.
    for (int s = 0; s < 300; s++) begin
      bit v = ($urandom() % 100) < 85;
      slot(v, W'($urandom()), 1'b1, v ? "R6 data" : "R5 idle");
    end

    // R7: strobes stop, lanes drain to zero.
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, W'($urandom()), "R7");

    // Restart, then reset mid-slot (R1).
    slot(1'b1, 28'h7E3C18F, 1'b0, "R2 restart");
    step(1'b1, 1'b1, 28'hFFFFFFF, "R2");
    step(1'b0, 1'b1, 28'hFFFFFFF, "R2");
    step(1'b0, 1'b1, 28'hFFFFFFF, "R2");
    rst_n = 1'b0; pclk_strobe = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(lane_out == '0 && !clk_lane, "R1 mid-reset", 32'({clk_lane, lane_out}), 32'h0);
    model_reset();
    rst_n = 1'b1;
    step(1'b0, 1'b0, '0, "R1");
    for (int s = 0; s < 20; s++) slot(1'b1, W'($urandom()), 1'b1, "R6 post-reset");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, "R7");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule